// File: doc/BRIEF.md
# Cache Profiling Event Counters

This block keeps eight event counters that profile how a flash cache behaves, with the instruction side and the data side counted apart. Each side feeds four single-cycle event pulses: access, tag lookup, tag hit and line-buffer hit. Each counter is `CNT_W` bits wide, 32 by default, and advances by one for each qualified pulse. A monitor enable gates all counting. While the enable is low, the counters keep their values, so one profiling run can collect counts over several separate code segments.

A clear command sets every counter to zero, but only while the monitor enable is high. A line-buffer hit is kept apart from tag activity: in a cycle that carries a line-buffer hit, the tag lookup and tag hit pulses of that side are not counted. A tag hit counts only together with a tag lookup. Software reads any counter through a plain combinational select port.

The event inputs are single-cycle pulses with no handshake. The cache never waits on this block, so the event pins have no valid/ready pair and no back-pressure. The counters cannot stall and accept a pulse on every cycle. The read port is a plain control and status path.

Top module: `cache_stat_counters`

## Requirements
- R1: After reset every counter reads zero. `rd_sel` picks a counter as follows: 0 instruction accesses, 1 instruction tag lookups, 2 instruction tag hits, 3 instruction line-buffer hits, and 4 to 7 the same four events for the data side. `rd_data` shows the selected counter in the same cycle.
- R2: While `mon_en` is 1 and `clr_stat` is 0, an access pulse on a side raises that side's access counter by exactly one on the next clock edge.
- R3: While `mon_en` is 0, no counter changes, whatever the event pulses do.
- R4: A `clr_stat` pulse with `mon_en` at 1 sets all eight counters to zero on the next edge.
- R5: A `clr_stat` pulse with `mon_en` at 0 is ignored, and every counter keeps its value.
- R6: A counter that holds all ones goes to zero on its next counted event.
- R7: When `clr_stat` and event pulses arrive in the same enabled cycle, the clear wins and every counter reads zero afterwards.
- R8: A line-buffer hit pulse raises that side's line-buffer counter. In that same cycle, the side's tag lookup and tag hit pulses are not counted.
- R9: A tag hit pulse raises the tag hit counter only when a tag lookup pulse on the same side comes with it and no line-buffer hit is present.
- R10: The instruction side and the data side count on their own: events on one side never move a counter of the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Monitor enable; gates counting and clearing |
| clr_stat | input | 1 | Clear command, one cycle |
| i_access | input | 1 | Instruction access pulse |
| i_lookup | input | 1 | Instruction tag lookup pulse |
| i_taghit | input | 1 | Instruction tag hit pulse |
| i_linehit | input | 1 | Instruction line-buffer hit pulse |
| d_access | input | 1 | Data access pulse |
| d_lookup | input | 1 | Data tag lookup pulse |
| d_taghit | input | 1 | Data tag hit pulse |
| d_linehit | input | 1 | Data line-buffer hit pulse |
| rd_sel | input | SEL_W (3) | Counter select, encoded as in R1 |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
Two functions can land on the same edge. A clear can coincide with event pulses, and it can also coincide with a deasserted monitor enable, where it must do nothing. The bench provokes both on purpose: it drives clear together with random pulses on both sides, once with the enable high and once with it low. A behavioural model then predicts the result, so all counters must read zero after the first case and must be unchanged after the second. A line-buffer hit that coincides with a lookup and a tag hit on the same side is provoked and judged in the same way.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int EV_PER_SIDE = 4;
  localparam int NUM_SIDES   = 2;

  // position of each event inside a side's counter group
  typedef enum logic [1:0] {
    EV_ACCESS  = 2'd0,
    EV_LOOKUP  = 2'd1,
    EV_TAGHIT  = 2'd2,
    EV_LINEHIT = 2'd3
  } ev_e;
endpackage

// File: rtl/stat_event_qual.sv
module stat_event_qual
  import stat_pkg::*;
(
  input  logic                   access,
  input  logic                   lookup,
  input  logic                   taghit,
  input  logic                   linehit,
  output logic [EV_PER_SIDE-1:0] inc
);
  logic tag_path;

  // a line-buffer hit bypasses the tag array, so tag events are dropped
  assign tag_path = lookup && !linehit;

  always_comb begin
    inc              = '0;
    inc[EV_ACCESS]   = access;
    inc[EV_LINEHIT]  = linehit;
    inc[EV_LOOKUP]   = tag_path;
    inc[EV_TAGHIT]   = tag_path && taghit;
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      if (clr)      q <= '0;
      else if (inc) q <= q + 1'b1;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)) else $error("counter moved while monitor off"); // R3

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr |=> q == '0) else $error("clear did not zero"); // R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && inc |=> q == W'($past(q) + 1'b1)) else $error("bad increment"); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !inc |=> $stable(q)) else $error("counter moved without event"); // R2
endmodule

// File: rtl/cache_stat_counters.sv
module cache_stat_counters
  import stat_pkg::*;
#(
  parameter  int CNT_W   = 32,
  localparam int NUM_CNT = NUM_SIDES * EV_PER_SIDE,
  localparam int SEL_W   = $clog2(NUM_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             clr_stat,
  input  logic             i_access,
  input  logic             i_lookup,
  input  logic             i_taghit,
  input  logic             i_linehit,
  input  logic             d_access,
  input  logic             d_lookup,
  input  logic             d_taghit,
  input  logic             d_linehit,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  logic [EV_PER_SIDE-1:0] raw_ev [NUM_SIDES];
  logic [EV_PER_SIDE-1:0] inc_ev [NUM_SIDES];
  logic [CNT_W-1:0]       cnt    [NUM_CNT];

  // side 0 is instruction, side 1 is data: fixes the R1 select encoding
  assign raw_ev[0] = {i_linehit, i_taghit, i_lookup, i_access};
  assign raw_ev[1] = {d_linehit, d_taghit, d_lookup, d_access};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    stat_event_qual u_qual (
      .access  (raw_ev[s][EV_ACCESS]),
      .lookup  (raw_ev[s][EV_LOOKUP]),
      .taghit  (raw_ev[s][EV_TAGHIT]),
      .linehit (raw_ev[s][EV_LINEHIT]),
      .inc     (inc_ev[s])
    );
    for (genvar e = 0; e < EV_PER_SIDE; e++) begin : g_ev
      stat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mon_en),
        .clr   (clr_stat),
        .inc   (inc_ev[s][e]),
        .q     (cnt[s*EV_PER_SIDE+e])
      );
    end
  end

  assign rd_data = cnt[rd_sel];

  AST_LINE_SKIPS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en && !clr_stat && i_linehit |=> cnt[EV_LOOKUP] == $past(cnt[EV_LOOKUP]))
    else $error("lookup counted on line-buffer hit"); // R8

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en && !clr_stat && !d_lookup |=> $stable(cnt[EV_PER_SIDE+EV_TAGHIT]))
    else $error("tag hit counted without lookup"); // R9

  AST_CLEAR_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en && clr_stat |=> $stable(cnt[EV_PER_SIDE+EV_ACCESS]))
    else $error("clear acted while monitor off"); // R5
endmodule

// File: tb/sim_cache_stat_counters.sv
`timescale 1ns/100ps
module sim_cache_stat_counters;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b0, clr_stat = 1'b0;
  logic i_access = 1'b0, i_lookup = 1'b0, i_taghit = 1'b0, i_linehit = 1'b0;
  logic d_access = 1'b0, d_lookup = 1'b0, d_taghit = 1'b0, d_linehit = 1'b0;
  logic [2:0]   rd_sel = 3'd0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] mdl [8];

  always #4 clk = ~clk;

  cache_stat_counters #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .clr_stat(clr_stat),
    .i_access(i_access), .i_lookup(i_lookup), .i_taghit(i_taghit), .i_linehit(i_linehit),
    .d_access(d_access), .d_lookup(d_lookup), .d_taghit(d_taghit), .d_linehit(d_linehit),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) begin
      rd_sel = k[2:0];
      #0.2;
      checks++;
      if (rd_data !== mdl[k]) begin
        errors++;
        $display("FAIL %s counter %0d got %0d expected %0d", tag, k, rd_data, mdl[k]);
      end
    end
  endtask

  // events packed as {linehit, taghit, lookup, access}
  task automatic step(input logic en, input logic clr,
                      input logic [3:0] iv, input logic [3:0] dv, input string tag);
    mon_en = en;
    clr_stat = clr;
    {i_linehit, i_taghit, i_lookup, i_access} = iv;
    {d_linehit, d_taghit, d_lookup, d_access} = dv;
    @(posedge clk);
    if (en) begin
      if (clr) begin
        for (int k = 0; k < 8; k++) mdl[k] = '0;
      end else begin
        for (int s = 0; s < 2; s++) begin
          logic [3:0] v;
          v = (s == 0) ? iv : dv;
          if (v[0]) mdl[s*4] = mdl[s*4] + 1'b1;
          if (v[3]) mdl[s*4+3] = mdl[s*4+3] + 1'b1;
          else if (v[1]) begin
            mdl[s*4+1] = mdl[s*4+1] + 1'b1;
            if (v[2]) mdl[s*4+2] = mdl[s*4+2] + 1'b1;
          end
        end
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [3:0] rnd4();
    return 4'($urandom());
  endfunction

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    for (int n = 0; n < 200; n++) step(1'b1, 1'b0, rnd4(), rnd4(), "R2 enabled random");
    for (int n = 0; n < 40; n++) step(1'b0, 1'b0, rnd4(), rnd4(), "R3 monitor off");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b1, rnd4(), rnd4(), "R5 clear while off");
    step(1'b1, 1'b0, 4'b0001, 4'b0001, "R2 single access");
    step(1'b1, 1'b1, 4'b0000, 4'b0000, "R4 plain clear");
    for (int n = 0; n < 30; n++) step(1'b1, 1'b0, rnd4(), rnd4(), "R2 refill");
    step(1'b1, 1'b1, 4'b1111, 4'b0111, "R7 clear with events");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 4'b1111, 4'b1110, "R8 line hit masks tag");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 4'b0100, 4'b0101, "R9 hit without lookup");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 4'b0000, 4'b0111, "R10 data side only");
    for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 4'b1011, 4'b0000, "R10 instr side only");
    for (int n = 0; n < 100; n++) step(1'b1, ($urandom() % 8) == 0, rnd4(), rnd4(), "R7 random clears");
    step(1'b1, 1'b1, 4'b0000, 4'b0000, "R4 clear before wrap");
    for (int n = 0; n < 1030; n++) step(1'b1, 1'b0, 4'b0011, 4'b0000, "R6 wrap");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule